// File: doc/BRIEF.md
# Shift-Add 8-Point Complex FFT Engine

This block computes an eight-point complex discrete Fourier transform, forward or inverse, using fixed-point arithmetic. Eight complex samples arrive in parallel, together with a one-cycle start pulse. The samples are placed on the input slots in bit-reversed order. The data then passes through three radix-2 decimation-in-time butterfly columns, and each column has one register stage. The eight transformed values come out in natural order with a one-cycle done pulse. The output holds its value until the next result replaces it.

The block contains no general multiplier. A twiddle of ±1 is a plain pass. A twiddle of ±j is a swap of the real and imaginary parts with one negation. The diagonal twiddles (±1±j)/√2 first add or subtract the two parts, then scale the result by a fixed shift-add constant of 181/256 (about 0.70703). Each column halves its result with rounding, so the full transform carries a gain of 1/8. The inverse control turns every twiddle into its complex conjugate.

Top module: `fft8_top`

## Requirements
- R1: While rst_ni is low, and after it is released until the first result, done_o is 0 and every output lane is 0.
- R2: A start_i pulse sampled on a rising edge makes done_o high for exactly one cycle, after the third rising edge counted from and including the sampling edge. Back-to-back starts give back-to-back done pulses, and done_o never rises without a start three edges earlier.
- R3: Input lane i of x_re_i/x_im_i (bits i*DW+DW-1 down to i*DW, two's complement) carries the sample whose time index is the 3-bit reversal of i. Output lane k of y_re_o/y_im_o (bits k*(DW+1)+DW down to k*(DW+1)) is the frequency bin k. Each butterfly gives floor((a±W·b+1)/2). W·b is exact for ±1 and ±j. For diagonal twiddles each part is floor(S·181/256), where S is the signed sum or difference of the real and imaginary parts of b.
- R4: With the bit-reversed lane mapping, an impulse of value 800 on lane 4 (time index 1) gives bin 0 = 100+0j, bin 2 = 0−100j and bin 4 = −100+0j.
- R5: A constant input of 800+0j on every lane gives 800+0j in bin 0 and zero in all other bins.
- R6: With inverse_i high when start_i is sampled, every twiddle is replaced by its conjugate (−j becomes +j, e^(−jπ/4) becomes e^(+jπ/4)). The result follows the R3 arithmetic with the conjugated twiddles.
- R7: Outputs change only on the edge that raises done_o. Input data and inverse_i presented without start_i have no effect on the outputs.
- R8: No internal value overflows its width for any input, including full-scale −2^(DW−1) on every lane, which gives −2^(DW−1) in bin 0.
- R9: Every output part is within 6 LSB of the exact DFT divided by 8, with sign −1 in the exponent for forward mode and +1 for inverse mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Marks the input lanes as a new transform |
| inverse_i | input | 1 | Selects conjugated twiddles, sampled with start_i |
| x_re_i | input | 8*DW | Real parts of the input lanes, bit-reversed order |
| x_im_i | input | 8*DW | Imaginary parts of the input lanes, bit-reversed order |
| done_o | output | 1 | One-cycle pulse when a new result is valid |
| y_re_o | output | 8*(DW+1) | Real parts of the bins, natural order |
| y_im_o | output | 8*(DW+1) | Imaginary parts of the bins, natural order |

## Verification
The overflow assertions rely on the inputs staying within DW-bit two's complement. Within that range, the halving in each column keeps every butterfly result inside DW+1 bits. The latency assertions assume nothing about the spacing of start pulses. The stimulus therefore includes back-to-back starts, isolated starts, and idle cycles that carry garbage data and a toggling inverse flag. Data vectors cover impulses, a DC value, full-scale negative values on every lane, and uniformly drawn full-range values in both modes. This keeps the stimulus inside the signed input range while reaching the largest diagonal-twiddle magnitudes.

// File: rtl/fft8_pkg.sv
package fft8_pkg;
  localparam int NPTS = 8;
  localparam int NSTG = 3;
  // 1/sqrt2 ~= 181/256 = 2^-1 + 2^-3 + 2^-4 + 2^-6 + 2^-8
  localparam int RC_SH = 8;
endpackage

// File: rtl/fft8_rot45.sv
module fft8_rot45 #(
  parameter int W = 18
) (
  input  logic signed [W-1:0] s_i,
  output logic signed [W-1:0] p_o
);
  localparam int PW = W + fft8_pkg::RC_SH;

  logic signed [PW-1:0] sx;
  logic signed [PW-1:0] acc;

  assign sx  = {{fft8_pkg::RC_SH{s_i[W-1]}}, s_i};
  assign acc = (sx <<< 7) + (sx <<< 5) + (sx <<< 4) + (sx <<< 2) + sx;
  // floor division by 2^RC_SH
  assign p_o = acc[PW-1:fft8_pkg::RC_SH];
endmodule

// File: rtl/fft8_twiddle.sv
module fft8_twiddle #(
  parameter int W = 17,
  parameter int E = 1
) (
  input  logic                inv_i,
  input  logic signed [W-1:0] re_i,
  input  logic signed [W-1:0] im_i,
  output logic signed [W:0]   re_o,
  output logic signed [W:0]   im_o
);
  logic signed [W:0] rx, ix;
  assign rx = {re_i[W-1], re_i};
  assign ix = {im_i[W-1], im_i};

  if (E == 2) begin : g_quarter
    // -j forward, +j inverse
    assign re_o = inv_i ? -ix : ix;
    assign im_o = inv_i ? rx  : -rx;
  end else begin : g_diag
    logic signed [W:0] sr, si;
    always_comb begin
      if (E == 1) begin
        sr = inv_i ? (rx - ix) : (rx + ix);
        si = inv_i ? (rx + ix) : (ix - rx);
      end else begin
        sr = inv_i ? (-rx - ix) : (ix - rx);
        si = inv_i ? (rx - ix)  : (-rx - ix);
      end
    end
    fft8_rot45 #(.W(W + 1)) u_rot_re (.s_i(sr), .p_o(re_o));
    fft8_rot45 #(.W(W + 1)) u_rot_im (.s_i(si), .p_o(im_o));
  end
endmodule

// File: rtl/fft8_stage.sv
module fft8_stage #(
  parameter int W = 17,
  parameter int S = 0
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             en_i,
  input  logic                             inv_i,
  input  logic [fft8_pkg::NPTS*W-1:0]      d_re_i,
  input  logic [fft8_pkg::NPTS*W-1:0]      d_im_i,
  output logic [fft8_pkg::NPTS*W-1:0]      q_re_o,
  output logic [fft8_pkg::NPTS*W-1:0]      q_im_o
);
  localparam int NP    = fft8_pkg::NPTS;
  localparam int H     = 1 << S;
  localparam int RSTEP = (NP / 2) >> S;

  for (genvar p = 0; p < NP / 2; p++) begin : g_bf
    localparam int TOP = (p / H) * 2 * H + (p % H);
    localparam int BOT = TOP + H;
    localparam int E   = (p % H) * RSTEP;

    logic signed [W-1:0] a_re, a_im, b_re, b_im;
    logic signed [W:0]   w_re, w_im;
    logic signed [W+1:0] s_re, s_im, t_re, t_im;
    logic signed [W:0]   hs_re, hs_im, ht_re, ht_im;
    logic        [W-1:0] qt_re, qt_im, qb_re, qb_im;

    assign a_re = d_re_i[TOP*W +: W];
    assign a_im = d_im_i[TOP*W +: W];
    assign b_re = d_re_i[BOT*W +: W];
    assign b_im = d_im_i[BOT*W +: W];

    if (E == 0) begin : g_pass
      assign w_re = {b_re[W-1], b_re};
      assign w_im = {b_im[W-1], b_im};
    end else begin : g_rot
      fft8_twiddle #(.W(W), .E(E)) u_tw (
        .inv_i (inv_i),
        .re_i  (b_re),
        .im_i  (b_im),
        .re_o  (w_re),
        .im_o  (w_im)
      );
    end

    assign s_re = {{2{a_re[W-1]}}, a_re} + {w_re[W], w_re} + (W+2)'(1);
    assign s_im = {{2{a_im[W-1]}}, a_im} + {w_im[W], w_im} + (W+2)'(1);
    assign t_re = {{2{a_re[W-1]}}, a_re} - {w_re[W], w_re} + (W+2)'(1);
    assign t_im = {{2{a_im[W-1]}}, a_im} - {w_im[W], w_im} + (W+2)'(1);

    // rounded halving
    assign hs_re = s_re[W+1:1];
    assign hs_im = s_im[W+1:1];
    assign ht_re = t_re[W+1:1];
    assign ht_im = t_im[W+1:1];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        qt_re <= '0;
        qt_im <= '0;
        qb_re <= '0;
        qb_im <= '0;
      end else if (en_i) begin
        qt_re <= hs_re[W-1:0];
        qt_im <= hs_im[W-1:0];
        qb_re <= ht_re[W-1:0];
        qb_im <= ht_im[W-1:0];
      end
    end

    assign q_re_o[TOP*W +: W] = qt_re;
    assign q_im_o[TOP*W +: W] = qt_im;
    assign q_re_o[BOT*W +: W] = qb_re;
    assign q_im_o[BOT*W +: W] = qb_im;

    assert_no_overflow_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_i |-> (hs_re[W] == hs_re[W-1]) && (hs_im[W] == hs_im[W-1]) &&
               (ht_re[W] == ht_re[W-1]) && (ht_im[W] == ht_im[W-1]));
  end
endmodule

// File: rtl/fft8_top.sv
module fft8_top #(
  parameter int DW = 16
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               start_i,
  input  logic                               inverse_i,
  input  logic [fft8_pkg::NPTS*DW-1:0]       x_re_i,
  input  logic [fft8_pkg::NPTS*DW-1:0]       x_im_i,
  output logic                               done_o,
  output logic [fft8_pkg::NPTS*(DW+1)-1:0]   y_re_o,
  output logic [fft8_pkg::NPTS*(DW+1)-1:0]   y_im_o
);
  localparam int NP = fft8_pkg::NPTS;
  localparam int NS = fft8_pkg::NSTG;
  localparam int OW = DW + 1;

  logic [NP*OW-1:0] c_re [NS+1];
  logic [NP*OW-1:0] c_im [NS+1];
  logic [NS-1:0]    vld, invq, en, inv;

  for (genvar i = 0; i < NP; i++) begin : g_sx
    assign c_re[0][i*OW +: OW] = {x_re_i[i*DW+DW-1], x_re_i[i*DW +: DW]};
    assign c_im[0][i*OW +: OW] = {x_im_i[i*DW+DW-1], x_im_i[i*DW +: DW]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld  <= '0;
      invq <= '0;
    end else begin
      vld  <= {vld[NS-2:0], start_i};
      invq <= {invq[NS-2:0], inverse_i};
    end
  end

  assign en  = {vld[NS-2:0], start_i};
  assign inv = {invq[NS-2:0], inverse_i};

  for (genvar s = 0; s < NS; s++) begin : g_col
    fft8_stage #(.W(OW), .S(s)) u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en[s]),
      .inv_i  (inv[s]),
      .d_re_i (c_re[s]),
      .d_im_i (c_im[s]),
      .q_re_o (c_re[s+1]),
      .q_im_o (c_im[s+1])
    );
  end

  assign done_o = vld[NS-1];
  assign y_re_o = c_re[NS];
  assign y_im_o = c_im[NS];

  assert_done_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> ##3 done_o);
  assert_done_source_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(start_i, 3));
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(y_re_o) && $stable(y_im_o)));
endmodule

// File: tb/sim_fft8_top.sv
`timescale 1ns/1ps
module sim_fft8_top;
  localparam int DW = 16;
  localparam int OW = DW + 1;

  typedef int vec8_t [8];
  typedef struct {
    bit    inv;
    vec8_t xr, xi, er, ei;
  } job_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic inverse = 1'b0;
  logic [8*DW-1:0] x_re = '0, x_im = '0;
  logic done;
  logic [8*OW-1:0] y_re, y_im;

  int total = 0, bad = 0, cyc = 0;
  job_t q[$];
  bit hist1 = 0, hist2 = 0, hist3 = 0;
  vec8_t held_r, held_i;
  bit held_inv = 0;
  vec8_t zv;

  always #5 clk = ~clk;

  fft8_top #(.DW(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .inverse_i(inverse),
    .x_re_i(x_re), .x_im_i(x_im), .done_o(done), .y_re_o(y_re), .y_im_o(y_im)
  );

  function automatic int brev(int i);
    return {i[0], i[1], i[2]};
  endfunction

  function automatic int rot(int s);
    return (s * 181) >>> 8;
  endfunction

  function automatic void twid(int e, bit inv, int br, int bi, output int wr, output int wi);
    case (e)
      0: begin wr = br; wi = bi; end
      1: begin wr = inv ? rot(br - bi) : rot(br + bi);
               wi = inv ? rot(br + bi) : rot(bi - br); end
      2: begin wr = inv ? -bi : bi; wi = inv ? br : -br; end
      default: begin wr = inv ? rot(-br - bi) : rot(bi - br);
                     wi = inv ? rot(br - bi) : rot(-br - bi); end
    endcase
  endfunction

  // behavioural radix-2 DIT, operating on bit-reversed lanes
  function automatic void model(bit inv, vec8_t ir, vec8_t ii, output vec8_t orr, output vec8_t oi);
    vec8_t r, m;
    int wr, wi, ar, ai;
    r = ir; m = ii;
    for (int s = 0; s < 3; s++) begin
      int h = 1 << s;
      for (int base = 0; base < 8; base += 2 * h) begin
        for (int j = 0; j < h; j++) begin
          twid(j * (4 >> s), inv, r[base+j+h], m[base+j+h], wr, wi);
          ar = r[base+j]; ai = m[base+j];
          r[base+j]   = (ar + wr + 1) >>> 1;
          m[base+j]   = (ai + wi + 1) >>> 1;
          r[base+j+h] = (ar - wr + 1) >>> 1;
          m[base+j+h] = (ai - wi + 1) >>> 1;
        end
      end
    end
    orr = r; oi = m;
  endfunction

  function automatic int yr(int k); return $signed(y_re[k*OW +: OW]); endfunction
  function automatic int yi(int k); return $signed(y_im[k*OW +: OW]); endfunction

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic ideal_check(job_t jb);
    real th, sr, si, sg;
    sg = jb.inv ? 1.0 : -1.0;
    for (int k = 0; k < 8; k++) begin
      sr = 0.0; si = 0.0;
      for (int n = 0; n < 8; n++) begin
        th = 2.0 * 3.14159265358979 * n * k / 8.0;
        sr += jb.xr[brev(n)] * $cos(th) - sg * jb.xi[brev(n)] * $sin(th);
        si += jb.xi[brev(n)] * $cos(th) + sg * jb.xr[brev(n)] * $sin(th);
      end
      sr /= 8.0; si /= 8.0;
      total++;
      if ((jb.er[k] - sr) > 6.0 || (sr - jb.er[k]) > 6.0 ||
          (jb.ei[k] - si) > 6.0 || (si - jb.ei[k]) > 6.0) begin
        bad++;
        $display("FAIL R9 bin %0d actual=%0d,%0d expected=%f,%f", k, jb.er[k], jb.ei[k], sr, si);
      end
    end
  endtask

  // per-cycle comparison, at the falling edge
  task automatic check_cycle();
    job_t jb;
    string tag;
    chk("R2", "done_o", int'(done), int'(hist3));
    tag = "R7";
    if (hist3) begin
      if (q.size() == 0) begin
        chk("R2", "queue underflow", 1, 0);
      end else begin
        jb = q.pop_front();
        held_r = jb.er; held_i = jb.ei; held_inv = jb.inv;
        ideal_check(jb);
      end
      tag = held_inv ? "R6" : "R3";
    end
    for (int k = 0; k < 8; k++) begin
      chk(tag, $sformatf("bin %0d re", k), yr(k), held_r[k]);
      chk(tag, $sformatf("bin %0d im", k), yi(k), held_i[k]);
    end
  endtask

  task automatic drive(bit st, bit inv, vec8_t r, vec8_t m);
    job_t jb;
    @(negedge clk);
    check_cycle();
    start = st; inverse = inv;
    for (int i = 0; i < 8; i++) begin
      x_re[i*DW +: DW] = DW'(r[i]);
      x_im[i*DW +: DW] = DW'(m[i]);
    end
    hist3 = hist2; hist2 = hist1; hist1 = st;
    if (st) begin
      jb.inv = inv; jb.xr = r; jb.xi = m;
      model(inv, r, m, jb.er, jb.ei);
      q.push_back(jb);
    end
  endtask

  function automatic vec8_t rnd();
    vec8_t v;
    for (int i = 0; i < 8; i++) v[i] = int'($urandom_range(65535)) - 32768;
    return v;
  endfunction

  // idle cycles with garbage data and toggling inverse (R7)
  task automatic idle(int n);
    for (int c = 0; c < n; c++) drive(0, c[0], rnd(), rnd());
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected<=100000", cyc);
      finish_run();
    end
  end

  initial begin
    vec8_t a, b;
    for (int i = 0; i < 8; i++) begin zv[i] = 0; held_r[i] = 0; held_i[i] = 0; end
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "done_o in reset", int'(done), 0);
    for (int k = 0; k < 8; k++) chk("R1", "bin re in reset", yr(k), 0);
    rst_n = 1'b1;
    idle(4);

    // R4: impulse of 800 on lane 4 (time index 1)
    a = zv; a[4] = 800;
    drive(1, 0, a, zv); idle(4);
    chk("R4", "bin0 re", yr(0), 100);   chk("R4", "bin0 im", yi(0), 0);
    chk("R4", "bin2 re", yr(2), 0);     chk("R4", "bin2 im", yi(2), -100);
    chk("R4", "bin4 re", yr(4), -100);  chk("R4", "bin4 im", yi(4), 0);

    // R5: DC
    for (int i = 0; i < 8; i++) a[i] = 800;
    drive(1, 0, a, zv); idle(4);
    chk("R5", "bin0 re", yr(0), 800);
    for (int k = 1; k < 8; k++) chk("R5", "other bin re", yr(k), 0);

    // R8: full-scale negative
    for (int i = 0; i < 8; i++) a[i] = -32768;
    drive(1, 0, a, a); idle(4);
    chk("R8", "bin0 re", yr(0), -32768);
    chk("R8", "bin0 im", yi(0), -32768);

    // R6: impulse in inverse mode, bin 2 must rotate the other way
    a = zv; a[4] = 800;
    drive(1, 1, a, zv); idle(4);
    chk("R6", "bin2 im", yi(2), 100);

    // R3/R6: back-to-back random transforms, mixed modes (R2 back-to-back)
    for (int t = 0; t < 40; t++) drive(1, t[1], rnd(), rnd());
    idle(5);
    // isolated starts with gaps
    for (int t = 0; t < 20; t++) begin
      drive(1, t[0], rnd(), rnd());
      idle(t % 4);
    end
    // alternating extremes stress the diagonal twiddles (R8)
    for (int i = 0; i < 8; i++) begin a[i] = i[0] ? 32767 : -32768; b[i] = i[1] ? -32768 : 32767; end
    drive(1, 0, a, b); drive(1, 1, b, a);
    idle(6);
    finish_run();
  end
endmodule